// File: doc/BRIEF.md
# SAD Block-Matching Motion Estimator

This block finds where a 16×16 reference macroblock best fits inside a larger target search window. It uses the sum of absolute differences (SAD) between the two blocks as its measure of fit. It tries every integer offset (dx, dy) within ±RANGE pixels in both axes. For each candidate it streams four reference bytes and four target bytes per cycle through a four-lane subtract-absolute-add datapath. Each pixel row of the macroblock is covered as four 4-pixel groups, so one candidate takes 64 group cycles.

The block has no storage of its own. It presents read addresses to two external synchronous memories, which return data one clock after the address. The reference memory is word-organised and returns four pixels per word. The target memory is byte-addressed and returns the four consecutive bytes that start at the requested address, so a group may begin at any pixel. Candidate results go to a minimum tracker. When the last candidate has been scored, a one-cycle done pulse presents the smallest SAD and its signed offset.

Top module: `sad_motion_est`

## Requirements
- R1: Each group cycle adds the absolute differences of four byte pairs to the candidate's running SAD. A candidate's SAD is the sum over all 256 pixel pairs, and the next candidate starts from zero.
- R2: Reference word address = row*4 + group. Lane i of `ref_data_i` (bits 8i+7:8i) is pixel column group*4+i of that row.
- R3: The SAD path is 16 bits wide and never wraps. A reference of all 255 against a target of all 0 reports 65280.
- R4: The target window is W = 16+2*RANGE pixels wide. For candidate (dx, dy), row r and group g, the target byte address is (dy+RANGE+r)*W + (dx+RANGE) + 4g. After the fourth group of a row, the address moves on by the row stride. Lane i of `tgt_data_i` is the byte at address+i.
- R5: Candidates are visited in raster order. The scan starts at (-RANGE, -RANGE), with dx changing fastest.
- R6: When several candidates share the smallest SAD, the one visited first in scan order is reported.
- R7: `mv_dx_o` and `mv_dy_o` are the two's-complement offset of the winning candidate, each in -RANGE..+RANGE.
- R8: `done_o` is high for exactly one cycle. It rises 64*(2*RANGE+1)^2 + 1 clock cycles after the edge that samples `start_i` (5185 cycles at RANGE=4).
- R9: `best_sad_o`, `mv_dx_o` and `mv_dy_o` change only in the cycle in which `done_o` is high, and hold their values until the next completion.
- R10: A `start_i` pulse that arrives while a search is running is ignored. It neither restarts the scan nor produces a second done.
- R11: After reset, `done_o` is 0 and `best_sad_o`, `mv_dx_o` and `mv_dy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a search (sampled while idle) |
| ref_addr_o | output | 6 | Reference word address |
| ref_data_i | input | 32 | Four reference pixels, one clock after the address |
| tgt_addr_o | output | 10 | Target byte address of the first pixel in the group |
| tgt_data_i | input | 32 | Four consecutive target pixels, one clock after the address |
| done_o | output | 1 | One-cycle completion pulse |
| best_sad_o | output | 16 | Smallest SAD of the last search |
| mv_dx_o | output | 4 | Signed horizontal offset of the best match |
| mv_dy_o | output | 4 | Signed vertical offset of the best match |

## Verification
A wrong group or row counter shows up as a wrong SAD or vector, but only at the next done, up to 5185 cycles later. The address-range check, however, flags a window overrun in the same cycle it happens. A bad candidate counter appears as a shifted done latency or as a vector that points one candidate off. This is why every search checks the latency to the exact cycle as well as the result. Tie handling and accumulator clearing are only visible in the reported offset and SAD. The stimulus therefore includes uniform images, a horizontally periodic image with five equal minima, and saturated pixels.

// File: rtl/sad_pkg.sv
package sad_pkg;

  typedef enum logic {
    SCAN_IDLE,
    SCAN_RUN
  } scan_state_e;

  function automatic int unsigned w_of(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sad_lane_sum.sv
module sad_lane_sum #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned LANES = 4,
  parameter int unsigned SUM_W = 10
) (
  input  logic [LANES*PIX_W-1:0] ref_i,
  input  logic [LANES*PIX_W-1:0] tgt_i,
  output logic [SUM_W-1:0]       sum_o
);

  logic [PIX_W-1:0] diff [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [PIX_W-1:0] a, b;
    assign a       = ref_i[l*PIX_W +: PIX_W];
    assign b       = tgt_i[l*PIX_W +: PIX_W];
    assign diff[l] = (a >= b) ? (a - b) : (b - a);
  end

  always_comb begin
    sum_o = '0;
    for (int l = 0; l < LANES; l++) sum_o = sum_o + SUM_W'(diff[l]);
  end

endmodule

// File: rtl/sad_scan_seq.sv
module sad_scan_seq
  import sad_pkg::*;
#(
  parameter int unsigned MB     = 16,
  parameter int unsigned LANES  = 4,
  parameter int unsigned RANGE  = 4,
  parameter int unsigned REF_AW = 6,
  parameter int unsigned TGT_AW = 10,
  parameter int unsigned MV_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [REF_AW-1:0] ref_addr_o,
  output logic [TGT_AW-1:0] tgt_addr_o,
  output logic              issue_o,
  output logic              first_o,
  output logic              last_o,
  output logic              final_o,
  output logic              cand0_o,
  output logic [MV_W-1:0]   dx_o,
  output logic [MV_W-1:0]   dy_o
);

  localparam int unsigned GRPS  = MB / LANES;
  localparam int unsigned WIN   = MB + 2 * RANGE;
  localparam int unsigned SPAN  = 2 * RANGE + 1;
  localparam int unsigned GRP_W = w_of(GRPS);
  localparam int unsigned ROW_W = w_of(MB);
  localparam int unsigned POS_W = w_of(SPAN);

  scan_state_e       state;
  logic [GRP_W-1:0]  grp;
  logic [ROW_W-1:0]  row;
  logic [POS_W-1:0]  cx, cy;
  logic [TGT_AW-1:0] row_base, cand_base, cand_next;
  logic              grp_end, row_end, cx_end, cy_end;

  assign grp_end = grp == GRP_W'(GRPS - 1);
  assign row_end = row == ROW_W'(MB - 1);
  assign cx_end  = cx == POS_W'(SPAN - 1);
  assign cy_end  = cy == POS_W'(SPAN - 1);

  // next candidate origin: step right, or wrap to the next window row
  always_comb begin
    if (cx_end && cy_end) cand_next = '0;
    else if (cx_end)      cand_next = cand_base + TGT_AW'(WIN - (SPAN - 1));
    else                  cand_next = cand_base + TGT_AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= SCAN_IDLE;
      grp       <= '0;
      row       <= '0;
      cx        <= '0;
      cy        <= '0;
      row_base  <= '0;
      cand_base <= '0;
    end else begin
      case (state)
        SCAN_IDLE: begin
          if (start_i) begin
            state     <= SCAN_RUN;
            grp       <= '0;
            row       <= '0;
            cx        <= '0;
            cy        <= '0;
            row_base  <= '0;
            cand_base <= '0;
          end
        end
        SCAN_RUN: begin
          grp <= grp_end ? '0 : grp + GRP_W'(1);
          if (grp_end) begin
            if (row_end) begin
              row       <= '0;
              cand_base <= cand_next;
              row_base  <= cand_next;
              if (cx_end) begin
                cx <= '0;
                cy <= cy_end ? '0 : cy + POS_W'(1);
                if (cy_end) state <= SCAN_IDLE;
              end else begin
                cx <= cx + POS_W'(1);
              end
            end else begin
              row      <= row + ROW_W'(1);
              row_base <= row_base + TGT_AW'(WIN);
            end
          end
        end
        default: state <= SCAN_IDLE;
      endcase
    end
  end

  assign ref_addr_o = REF_AW'(row) * REF_AW'(GRPS) + REF_AW'(grp);
  assign tgt_addr_o = row_base + TGT_AW'(grp) * TGT_AW'(LANES);
  assign issue_o    = state == SCAN_RUN;
  assign first_o    = (grp == '0) && (row == '0);
  assign last_o     = grp_end && row_end;
  assign final_o    = last_o && cx_end && cy_end;
  assign cand0_o    = (cx == '0) && (cy == '0);
  assign dx_o       = MV_W'(cx) - MV_W'(RANGE);
  assign dy_o       = MV_W'(cy) - MV_W'(RANGE);

endmodule

// File: rtl/sad_min_track.sv
module sad_min_track #(
  parameter int unsigned ACC_W = 16,
  parameter int unsigned SUM_W = 10,
  parameter int unsigned MV_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             first_i,
  input  logic             last_i,
  input  logic             final_i,
  input  logic             cand0_i,
  input  logic [MV_W-1:0]  dx_i,
  input  logic [MV_W-1:0]  dy_i,
  input  logic [SUM_W-1:0] sum_i,
  output logic [ACC_W-1:0] best_sad_o,
  output logic [MV_W-1:0]  mv_dx_o,
  output logic [MV_W-1:0]  mv_dy_o,
  output logic             done_o
);

  logic [ACC_W-1:0] acc, run_sad, total;
  logic [MV_W-1:0]  run_dx, run_dy;
  logic             take;

  assign total = (first_i ? '0 : acc) + ACC_W'(sum_i);
  // strict less-than keeps the earliest of equal candidates
  assign take  = cand0_i || (total < run_sad);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc        <= '0;
      run_sad    <= '0;
      run_dx     <= '0;
      run_dy     <= '0;
      best_sad_o <= '0;
      mv_dx_o    <= '0;
      mv_dy_o    <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (valid_i) begin
        acc <= total;
        if (last_i && take) begin
          run_sad <= total;
          run_dx  <= dx_i;
          run_dy  <= dy_i;
        end
        if (final_i) begin
          best_sad_o <= take ? total : run_sad;
          mv_dx_o    <= take ? dx_i  : run_dx;
          mv_dy_o    <= take ? dy_i  : run_dy;
          done_o     <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sad_motion_est.sv
module sad_motion_est #(
  parameter  int unsigned PIX_W  = 8,
  parameter  int unsigned LANES  = 4,
  parameter  int unsigned MB     = 16,
  parameter  int unsigned RANGE  = 4,
  parameter  int unsigned ACC_W  = 16,
  localparam int unsigned WIN    = MB + 2 * RANGE,
  localparam int unsigned REF_AW = sad_pkg::w_of(MB * MB / LANES),
  localparam int unsigned TGT_AW = sad_pkg::w_of(WIN * WIN),
  localparam int unsigned MV_W   = $clog2(RANGE + 1) + 1,
  localparam int unsigned DAT_W  = LANES * PIX_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  output logic [REF_AW-1:0]       ref_addr_o,
  input  logic [DAT_W-1:0]        ref_data_i,
  output logic [TGT_AW-1:0]       tgt_addr_o,
  input  logic [DAT_W-1:0]        tgt_data_i,
  output logic                    done_o,
  output logic [ACC_W-1:0]        best_sad_o,
  output logic signed [MV_W-1:0]  mv_dx_o,
  output logic signed [MV_W-1:0]  mv_dy_o
);

  localparam int unsigned SUM_W = PIX_W + sad_pkg::w_of(LANES);

  logic            s_issue, s_first, s_last, s_final, s_cand0;
  logic [MV_W-1:0] s_dx, s_dy;

  // tags delayed one cycle to line up with the memory read latency
  logic            q_valid, q_first, q_last, q_final, q_cand0;
  logic [MV_W-1:0] q_dx, q_dy;

  logic [SUM_W-1:0] grp_sum;
  logic [MV_W-1:0]  out_dx, out_dy;

  sad_scan_seq #(
    .MB(MB), .LANES(LANES), .RANGE(RANGE),
    .REF_AW(REF_AW), .TGT_AW(TGT_AW), .MV_W(MV_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ref_addr_o (ref_addr_o),
    .tgt_addr_o (tgt_addr_o),
    .issue_o    (s_issue),
    .first_o    (s_first),
    .last_o     (s_last),
    .final_o    (s_final),
    .cand0_o    (s_cand0),
    .dx_o       (s_dx),
    .dy_o       (s_dy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_valid <= 1'b0;
      q_first <= 1'b0;
      q_last  <= 1'b0;
      q_final <= 1'b0;
      q_cand0 <= 1'b0;
      q_dx    <= '0;
      q_dy    <= '0;
    end else begin
      q_valid <= s_issue;
      q_first <= s_first;
      q_last  <= s_last;
      q_final <= s_final;
      q_cand0 <= s_cand0;
      q_dx    <= s_dx;
      q_dy    <= s_dy;
    end
  end

  sad_lane_sum #(.PIX_W(PIX_W), .LANES(LANES), .SUM_W(SUM_W)) u_lanes (
    .ref_i (ref_data_i),
    .tgt_i (tgt_data_i),
    .sum_o (grp_sum)
  );

  sad_min_track #(.ACC_W(ACC_W), .SUM_W(SUM_W), .MV_W(MV_W)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (q_valid),
    .first_i    (q_first),
    .last_i     (q_last),
    .final_i    (q_final),
    .cand0_i    (q_cand0),
    .dx_i       (q_dx),
    .dy_i       (q_dy),
    .sum_i      (grp_sum),
    .best_sad_o (best_sad_o),
    .mv_dx_o    (out_dx),
    .mv_dy_o    (out_dy),
    .done_o     (done_o)
  );

  assign mv_dx_o = out_dx;
  assign mv_dy_o = out_dy;

endmodule

// File: rtl/sad_motion_est_chk.sv
module sad_motion_est_chk #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned MB     = 16,
  parameter int unsigned RANGE  = 4,
  parameter int unsigned ACC_W  = 16,
  parameter int unsigned TGT_AW = 10,
  parameter int unsigned MV_W   = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [TGT_AW-1:0]      tgt_addr_o,
  input logic                   done_o,
  input logic [ACC_W-1:0]       best_sad_o,
  input logic signed [MV_W-1:0] mv_dx_o,
  input logic signed [MV_W-1:0] mv_dy_o
);

  localparam int unsigned WIN     = MB + 2 * RANGE;
  localparam int unsigned SAD_MAX = MB * MB * ((1 << PIX_W) - 1);

  a_r8_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(best_sad_o) && $stable(mv_dx_o) && $stable(mv_dy_o)));

  a_r7_mv_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(mv_dx_o) >= -int'(RANGE)) && (int'(mv_dx_o) <= int'(RANGE)) &&
    (int'(mv_dy_o) >= -int'(RANGE)) && (int'(mv_dy_o) <= int'(RANGE)));

  a_r3_sad_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(best_sad_o) <= int'(SAD_MAX));

  a_r4_tgt_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(tgt_addr_o) + int'(LANES) <= int'(WIN * WIN));

endmodule

bind sad_motion_est sad_motion_est_chk #(
  .PIX_W(PIX_W), .LANES(LANES), .MB(MB), .RANGE(RANGE),
  .ACC_W(ACC_W), .TGT_AW(TGT_AW), .MV_W(MV_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tgt_addr_o (tgt_addr_o),
  .done_o     (done_o),
  .best_sad_o (best_sad_o),
  .mv_dx_o    (mv_dx_o),
  .mv_dy_o    (mv_dy_o)
);

// File: tb/sad_motion_est_tb.sv
module sad_motion_est_tb;

  localparam int MB    = 16;
  localparam int RANGE = 4;
  localparam int WIN   = MB + 2 * RANGE;
  localparam int SPAN  = 2 * RANGE + 1;
  localparam int LAT   = 64 * SPAN * SPAN + 1;

  typedef struct {
    int sad;
    int dx;
    int dy;
    int start_cyc;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  ref_addr_o;
  logic [31:0] ref_data_i;
  logic [9:0]  tgt_addr_o;
  logic [31:0] tgt_data_i;
  logic        done_o;
  logic [15:0] best_sad_o;
  logic signed [3:0] mv_dx_o, mv_dy_o;

  logic [7:0] ref_mem [MB*MB];
  logic [7:0] tgt_mem [WIN*WIN];

  exp_t q[$];
  exp_t last_exp;
  int   total = 0, bad = 0, cyc = 0;
  bit   finished = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz
  always @(posedge clk_i) cyc <= cyc + 1;

  sad_motion_est u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .ref_addr_o(ref_addr_o), .ref_data_i(ref_data_i),
    .tgt_addr_o(tgt_addr_o), .tgt_data_i(tgt_data_i),
    .done_o(done_o), .best_sad_o(best_sad_o),
    .mv_dx_o(mv_dx_o), .mv_dy_o(mv_dy_o)
  );

  // synchronous memories, one clock of read latency
  always @(posedge clk_i) begin
    for (int i = 0; i < 4; i++) begin
      ref_data_i[i*8 +: 8] <= ref_mem[int'(ref_addr_o)*4 + i];
      tgt_data_i[i*8 +: 8] <= tgt_mem[(int'(tgt_addr_o) + i) % (WIN*WIN)];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // reference model: raster scan, strict less-than keeps the earliest
  function automatic exp_t model();
    exp_t e;
    e.sad = -1; e.dx = 0; e.dy = 0; e.start_cyc = 0;
    for (int cy = 0; cy < SPAN; cy++)
      for (int cx = 0; cx < SPAN; cx++) begin
        int s = 0;
        for (int r = 0; r < MB; r++)
          for (int c = 0; c < MB; c++) begin
            int a = ref_mem[r*MB + c];
            int b = tgt_mem[(cy + r)*WIN + cx + c];
            s += (a > b) ? a - b : b - a;
          end
        if (e.sad < 0 || s < e.sad) begin
          e.sad = s; e.dx = cx - RANGE; e.dy = cy - RANGE;
        end
      end
    return e;
  endfunction

  task automatic run_search(input bit mid_start);
    exp_t e;
    e = model();
    @(negedge clk_i); start_i = 1'b1;
    @(posedge clk_i); #1;
    e.start_cyc = cyc;
    q.push_back(e);
    last_exp = e;
    @(negedge clk_i); start_i = 1'b0;
    if (mid_start) begin  // R10: start during scan must be ignored
      repeat (1000) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0;
    end
    while (q.size() != 0) @(negedge clk_i);
    if (mid_start) repeat (LAT + 50) @(negedge clk_i);
    else repeat (20) @(negedge clk_i);
    // R9: result held after completion
    check(best_sad_o == 16'(last_exp.sad), "R9 hold sad", int'(best_sad_o), last_exp.sad);
    check(int'(mv_dx_o) == last_exp.dx && int'(mv_dy_o) == last_exp.dy,
          "R9 hold mv", int'(mv_dx_o)*100 + int'(mv_dy_o), last_exp.dx*100 + last_exp.dy);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && done_o) begin
        if (q.size() == 0) begin
          check(1'b0, "R10 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(best_sad_o == 16'(e.sad), "R1 best sad", int'(best_sad_o), e.sad);
          check(int'(mv_dx_o) == e.dx, "R7 mv dx", int'(mv_dx_o), e.dx);
          check(int'(mv_dy_o) == e.dy, "R7 mv dy", int'(mv_dy_o), e.dy);
          check(cyc - e.start_cyc == LAT, "R8 done latency", cyc - e.start_cyc, LAT);
        end
        @(negedge clk_i);
        check(!done_o, "R8 done width", int'(done_o), 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    check(1'b0, "watchdog", cyc, 0);
    finish_up();
  end

  initial begin
    for (int i = 0; i < MB*MB; i++) ref_mem[i] = '0;
    for (int i = 0; i < WIN*WIN; i++) tgt_mem[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    check(!done_o, "R11 done", int'(done_o), 0);
    check(best_sad_o == 0, "R11 sad", int'(best_sad_o), 0);
    check(mv_dx_o == 0 && mv_dy_o == 0, "R11 mv", int'(mv_dx_o), 0);

    // R1 R2 R4: exact copy embedded at (+2,-3) in noise
    for (int i = 0; i < WIN*WIN; i++) tgt_mem[i] = 8'($urandom_range(0, 255));
    for (int r = 0; r < MB; r++)
      for (int c = 0; c < MB; c++)
        ref_mem[r*MB + c] = tgt_mem[(r + 1)*WIN + c + 6];
    run_search(1'b0);

    // R5 R6: uniform images, every candidate ties, expect (-4,-4)
    for (int i = 0; i < WIN*WIN; i++) tgt_mem[i] = 8'd77;
    for (int i = 0; i < MB*MB; i++) ref_mem[i] = 8'd77;
    run_search(1'b0);

    // R3: saturated difference, 65280 without wrap
    for (int i = 0; i < WIN*WIN; i++) tgt_mem[i] = 8'd0;
    for (int i = 0; i < MB*MB; i++) ref_mem[i] = 8'd255;
    run_search(1'b0);

    // R6: horizontally periodic target, five equal minima on dy=0
    for (int y = 0; y < WIN; y++) begin
      logic [7:0] p0, p1;
      p0 = 8'($urandom_range(0, 255));
      p1 = 8'($urandom_range(0, 255));
      for (int x = 0; x < WIN; x++) tgt_mem[y*WIN + x] = x[0] ? p1 : p0;
    end
    for (int r = 0; r < MB; r++)
      for (int c = 0; c < MB; c++)
        ref_mem[r*MB + c] = tgt_mem[(r + RANGE)*WIN + c + RANGE];
    run_search(1'b0);

    // R4 R5: match at the far corner (+4,+4), reference slightly perturbed
    for (int i = 0; i < WIN*WIN; i++) tgt_mem[i] = 8'($urandom_range(0, 255));
    for (int r = 0; r < MB; r++)
      for (int c = 0; c < MB; c++)
        ref_mem[r*MB + c] = tgt_mem[(r + 8)*WIN + c + 8] ^ 8'(c == 5);
    run_search(1'b0);

    // R1: pure noise on both sides
    for (int i = 0; i < MB*MB; i++) ref_mem[i] = 8'($urandom_range(0, 255));
    run_search(1'b0);

    // R10: second start in mid-scan ignored
    for (int r = 0; r < MB; r++)
      for (int c = 0; c < MB; c++)
        ref_mem[r*MB + c] = tgt_mem[(r + 6)*WIN + c + 1];
    run_search(1'b1);

    finish_up();
  end

endmodule